// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Status Bank

This block collects per-channel event pulses from a multi-channel DMA engine and keeps them as sticky status bits for software. Each of the 16 channels reports a completion pulse and four kinds of error pulse: burst timeout, request timeout, transfer error and buffer overflow. Each error kind has its own status register. Every error pulse also sets the channel's bit in the shared interrupt status register. Software can therefore clear the error record and the interrupt record on their own. A mask register selects which channels may raise the single combined interrupt line.

Software reaches the registers through a plain register port. The port has a byte address, write data, a write enable and combinational read data. There is no stream traffic at this block's edge, so no valid/ready handshake is used. The event inputs are single-cycle pulses sampled on every clock, and the read data follows the address in the same cycle. A control register enables event capture and offers a self-clearing reset request. A burst-timeout control register holds an enable bit and a 15-bit count, and both values are driven out to the transfer engine.

Top module: `dma_irq_status_bank`

## Requirements
- R1: After reset every status register reads 0, the mask register (0x08) reads 0xFFFF, the control register (0x00) and the burst-timeout control register (0x1C) read 0, and `irq` is low.
- R2: A pulse on `done_pulse[i]` while capture is enabled sets bit i of the interrupt status register (0x04). The bit stays set until software clears it.
- R3: A pulse on an error input for channel i while capture is enabled sets bit i of that kind's status register and also bit i of 0x04. The registers are burst timeout at 0x0C, request timeout at 0x10, transfer error at 0x14 and buffer overflow at 0x18.
- R4: Writing to any status register clears exactly the bits written as 1 and leaves the other bits of that register unchanged. Clearing an error register does not touch 0x04, and clearing 0x04 does not touch an error register.
- R5: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: In the mask register, bit i = 1 blocks channel i and bit i = 0 lets it through. `irq` is high exactly when some bit of (0x04 AND NOT mask) is 1.
- R7: Bit 0 of the control register enables capture and reads back as written. While it is 0, event pulses change no status register.
- R8: Writing 1 to control bit 1 clears all status registers, sets the mask to 0xFFFF and clears 0x1C, all in the following cycle. In that case the reset wins over any event pulse of the same cycle. Bit 1 always reads 0, and bit 0 takes the value written with it.
- R9: The burst-timeout control register keeps write-data bits 15:0. Bit 15 drives `bto_enable` and bits 14:0 drive `bto_count`. Bits 31:16 read 0.
- R10: An address whose two low bits are not 00 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_pulse | input | 16 | Per-channel completion pulse |
| err_burst | input | 16 | Per-channel burst-timeout pulse |
| err_request | input | 16 | Per-channel request-timeout pulse |
| err_transfer | input | 16 | Per-channel transfer-error pulse |
| err_overflow | input | 16 | Per-channel buffer-overflow pulse |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| irq | output | 1 | Combined interrupt |
| bto_enable | output | 1 | Burst-timeout enable |
| bto_count | output | 15 | Burst-timeout count |

## Verification
An event pulse or a register write presented before clock edge N updates the state at edge N. The read data, `irq` and the timeout outputs are combinational from that state, so they show the new value straight after edge N with no extra latency. The bench changes inputs only just after a falling edge. It advances one rising edge per step, updates its reference state at that rising edge, and does all reads within the low half-period that follows, before the next rising edge.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int OFF_CTRL     = 0;
  localparam int OFF_ISTAT    = 4;
  localparam int OFF_MASK     = 8;
  localparam int OFF_ERR_BASE = 12;
  localparam int OFF_BTOC     = 28;
  localparam int ERR_KINDS    = 4;

  // The order of the kinds fixes their register offsets.
  typedef enum logic [1:0] {
    ERR_BURST    = 2'd0,
    ERR_REQUEST  = 2'd1,
    ERR_TRANSFER = 2'd2,
    ERR_OVERFLOW = 2'd3
  } err_kind_e;

  function automatic int err_offset(input int kind);
    return OFF_ERR_BASE + 4 * kind;
  endfunction
endpackage

// File: rtl/irqbank_w1c_reg.sv
module irqbank_w1c_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_clr) q <= '0;
    else               q <= (q & ~clr_mask) | set_vec;
  end

  // R5: a set always lands, even with a same-cycle clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && set_vec != '0) |=> ((q & $past(set_vec)) == $past(set_vec)));

  // R8: the soft reset empties the register
  a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (q == '0));

  // R4: bits not written as 1 survive a clear
  a_r4_keep_unmarked: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !soft_clr) |=>
      ((q & ($past(q) & ~$past(clr_vec))) == ($past(q) & ~$past(clr_vec))));
endmodule

// File: rtl/irqbank_cfg_regs.sv
module irqbank_cfg_regs
  import irqbank_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int BTO_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             enable,
  output logic             soft_clr,
  output logic [NCH-1:0]   mask,
  output logic [BTO_W:0]   btoc
);
  localparam int USED_W = (NCH > BTO_W + 1) ? NCH : BTO_W + 1;

  logic ctrl_hit, mask_hit, btoc_hit;
  logic unused_cfg;

  assign ctrl_hit   = we && (addr == AW'(OFF_CTRL));
  assign mask_hit   = we && (addr == AW'(OFF_MASK));
  assign btoc_hit   = we && (addr == AW'(OFF_BTOC));
  assign soft_clr   = ctrl_hit && wdata[1];
  assign unused_cfg = ^wdata[DW-1:USED_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      mask   <= '1;
      btoc   <= '0;
    end else begin
      if (ctrl_hit) enable <= wdata[0];
      if (soft_clr) begin
        mask <= '1;
        btoc <= '0;
      end else begin
        if (mask_hit) mask <= wdata[NCH-1:0];
        if (btoc_hit) btoc <= wdata[BTO_W:0];
      end
    end
  end

  // R8: the reset request restores mask and timeout defaults
  a_r8_cfg_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (mask == '1 && btoc == '0));

  // R7: the enable follows the written bit 0
  a_r7_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> (enable == $past(wdata[0])));
endmodule

// File: rtl/dma_irq_status_bank.sv
module dma_irq_status_bank
  import irqbank_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int BTO_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   done_pulse,
  input  logic [NCH-1:0]   err_burst,
  input  logic [NCH-1:0]   err_request,
  input  logic [NCH-1:0]   err_transfer,
  input  logic [NCH-1:0]   err_overflow,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_we,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq,
  output logic             bto_enable,
  output logic [BTO_W-1:0] bto_count
);
  logic             enable, soft_clr;
  logic [NCH-1:0]   mask, istat, err_any, istat_set;
  logic [BTO_W:0]   btoc;
  logic [NCH-1:0]   err_in [ERR_KINDS];
  logic [NCH-1:0]   err_q  [ERR_KINDS];

  assign err_in[int'(ERR_BURST)]    = err_burst;
  assign err_in[int'(ERR_REQUEST)]  = err_request;
  assign err_in[int'(ERR_TRANSFER)] = err_transfer;
  assign err_in[int'(ERR_OVERFLOW)] = err_overflow;

  irqbank_cfg_regs #(.NCH(NCH), .DW(DW), .AW(AW), .BTO_W(BTO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .enable(enable), .soft_clr(soft_clr), .mask(mask), .btoc(btoc)
  );

  always_comb begin
    err_any = '0;
    for (int k = 0; k < ERR_KINDS; k++) err_any = err_any | err_in[k];
  end

  assign istat_set = enable ? (done_pulse | err_any) : '0;

  irqbank_w1c_reg #(.W(NCH)) u_istat (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .set_vec(istat_set),
    .clr_wr(reg_we && (reg_addr == AW'(OFF_ISTAT))),
    .clr_vec(reg_wdata[NCH-1:0]), .q(istat)
  );

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
    logic [NCH-1:0] set_k;
    assign set_k = enable ? err_in[k] : '0;
    irqbank_w1c_reg #(.W(NCH)) u_err (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .set_vec(set_k),
      .clr_wr(reg_we && (reg_addr == AW'(err_offset(k)))),
      .clr_vec(reg_wdata[NCH-1:0]), .q(err_q[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFF_CTRL):  reg_rdata = DW'(enable);
      AW'(OFF_ISTAT): reg_rdata = DW'(istat);
      AW'(OFF_MASK):  reg_rdata = DW'(mask);
      AW'(OFF_BTOC):  reg_rdata = DW'(btoc);
      default: begin
        for (int k = 0; k < ERR_KINDS; k++)
          if (reg_addr == AW'(err_offset(k))) reg_rdata = DW'(err_q[k]);
      end
    endcase
  end

  assign irq        = |(istat & ~mask);
  assign bto_enable = btoc[BTO_W];
  assign bto_count  = btoc[BTO_W-1:0];

  // R3: an enabled error pulse reaches the interrupt status
  a_r3_err_sets_istat: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !soft_clr && err_any != '0) |=>
      ((istat & $past(err_any)) == $past(err_any)));

  // R7: with capture off and no write, status holds
  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !reg_we) |=> (istat == $past(istat)));

  // R6: a full mask keeps the line low
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq);
endmodule

// File: tb/sim_dma_irq_status_bank.sv
`timescale 1ns/100ps
module sim_dma_irq_status_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] done_p = '0, eb = '0, er = '0, ex = '0, eo = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq, bto_en;
  logic [14:0] bto_cnt;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [15:0] m_ist, m_mask, m_bto;
  logic [15:0] m_err [4];
  logic        m_en;

  always #2.5 clk = ~clk;

  dma_irq_status_bank u0 (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_p), .err_burst(eb),
    .err_request(er), .err_transfer(ex), .err_overflow(eo),
    .reg_addr(addr), .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata),
    .irq(irq), .bto_enable(bto_en), .bto_count(bto_cnt)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'd0:  return {31'd0, m_en};
      5'd4:  return {16'd0, m_ist};
      5'd8:  return {16'd0, m_mask};
      5'd12: return {16'd0, m_err[0]};
      5'd16: return {16'd0, m_err[1]};
      5'd20: return {16'd0, m_err[2]};
      5'd24: return {16'd0, m_err[3]};
      5'd28: return {16'd0, m_bto};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_ist = '0; m_mask = '1; m_bto = '0; m_en = 1'b0;
    for (int k = 0; k < 4; k++) m_err[k] = '0;
  endtask

  task automatic model_step();
    logic [15:0] e [4];
    logic [15:0] any;
    logic        en_old, ctrl_w;
    e[0] = eb; e[1] = er; e[2] = ex; e[3] = eo;
    any = eb | er | ex | eo;
    en_old = m_en;
    ctrl_w = we && addr == 5'd0;
    if (ctrl_w && wdata[1]) begin
      m_ist = '0; m_mask = '1; m_bto = '0;
      for (int k = 0; k < 4; k++) m_err[k] = '0;
    end else begin
      m_ist = (m_ist & ~((we && addr == 5'd4) ? wdata[15:0] : 16'd0))
              | (en_old ? (done_p | any) : 16'd0);
      for (int k = 0; k < 4; k++)
        m_err[k] = (m_err[k] & ~((we && addr == 5'(12 + 4 * k)) ? wdata[15:0] : 16'd0))
                   | (en_old ? e[k] : 16'd0);
      if (we && addr == 5'd8)  m_mask = wdata[15:0];
      if (we && addr == 5'd28) m_bto  = wdata[15:0];
    end
    if (ctrl_w) m_en = wdata[0];
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    we = 1'b0; done_p = '0; eb = '0; er = '0; ex = '0; eo = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    cycle();
  endtask

  task automatic rd(input logic [4:0] a, input string req, input logic [31:0] exp);
    addr = a; we = 1'b0;
    #0.2;
    chk(req, rdata, exp);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 8; k++) rd(5'(4 * k), req, model_read(5'(4 * k)));
    chk({req, " irq"}, {31'd0, irq}, {31'd0, |(m_ist & ~m_mask)});
    chk({req, " bto"}, {16'd0, bto_en, bto_cnt}, {16'd0, m_bto});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #12 rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    check_all("R1");
    chk("R1 mask", {16'd0, m_mask}, 32'h0000FFFF);

    // R7: capture disabled ignores events
    done_p = 16'hFFFF; eb = 16'h00F0;
    cycle();
    rd(5'd4, "R7 disabled istat", 32'd0);
    rd(5'd12, "R7 disabled burst", 32'd0);

    wr(5'd0, 32'h1);
    rd(5'd0, "R7 enable readback", 32'h1);

    // R2: completion sets sticky status, masked output stays low
    done_p = 16'h0005;
    cycle();
    rd(5'd4, "R2 istat", 32'h5);
    cycle();
    rd(5'd4, "R2 sticky", 32'h5);
    chk("R6 masked irq", {31'd0, irq}, 32'd0);

    // R6: unmask channel 0
    wr(5'd8, 32'h0000FFFE);
    chk("R6 unmasked irq", {31'd0, irq}, 32'd1);

    // R3: error kinds
    eb = 16'h0100; eo = 16'h8000; er = 16'h0010; ex = 16'h0020;
    cycle();
    rd(5'd12, "R3 burst", 32'h0100);
    rd(5'd16, "R3 request", 32'h0010);
    rd(5'd20, "R3 transfer", 32'h0020);
    rd(5'd24, "R3 overflow", 32'h8000);
    rd(5'd4, "R3 istat union", 32'h8135);

    // R4: independent clears
    wr(5'd4, 32'h0000_0100);
    rd(5'd4, "R4 istat cleared one", 32'h8035);
    rd(5'd12, "R4 burst untouched", 32'h0100);
    wr(5'd12, 32'h0000_0100);
    rd(5'd12, "R4 burst cleared", 32'h0);
    rd(5'd4, "R4 istat untouched", 32'h8035);

    // R5: set wins over same-cycle clear
    done_p = 16'h0002; addr = 5'd4; wdata = 32'h0000_0003; we = 1'b1;
    cycle();
    rd(5'd4, "R5 set wins", 32'h8036);

    // R9: timeout control
    wr(5'd28, 32'h1234_ABCD);
    rd(5'd28, "R9 btoc readback", 32'h0000_ABCD);
    chk("R9 bto_enable", {31'd0, bto_en}, 32'd1);
    chk("R9 bto_count", {17'd0, bto_cnt}, 32'h2BCD);

    // R10: unaligned address
    wr(5'd5, 32'hFFFF_FFFF);
    rd(5'd5, "R10 unaligned read", 32'd0);
    check_all("R10 unchanged");

    // R8: reset request wins over same-cycle events
    done_p = 16'hFFFF; eo = 16'hFFFF; addr = 5'd0; wdata = 32'h3; we = 1'b1;
    cycle();
    rd(5'd4, "R8 istat", 32'd0);
    rd(5'd24, "R8 overflow", 32'd0);
    rd(5'd8, "R8 mask", 32'h0000FFFF);
    rd(5'd28, "R8 btoc", 32'd0);
    rd(5'd0, "R8 ctrl", 32'h1);

    // Random mix, all requirements R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      done_p = (r[3:0] == 0) ? 16'($urandom) : 16'd0;
      eb = (r[7:4] == 0) ? 16'($urandom) : 16'd0;
      er = (r[7:4] == 1) ? 16'($urandom) : 16'd0;
      ex = (r[7:4] == 2) ? 16'($urandom) : 16'd0;
      eo = (r[7:4] == 3) ? 16'($urandom) : 16'd0;
      we = r[8] & r[9];
      addr = (r[12:10] == 0) ? 5'($urandom) : 5'(4 * (r[15:13]));
      wdata = $urandom;
      if (addr == 5'd0) begin
        wdata[0] = (r[18:16] != 0);
        wdata[1] = (r[22:19] == 0);
      end
      cycle();
      check_all("RND R2-mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule